// File: doc/BRIEF.md
# Configuration Target Sequencer

This block is the control state machine that a programmable device runs on its configuration pins. It runs on a system clock. It watches a power-on-reset-complete input and an active-low reconfigure request. It controls two open-drain handshake lines, status and done, by choosing whether to pull each one low. It reads the level of both lines back through input pins, because an external pull-up raises a line once the block lets go of it. A serial data bit arrives with its own configuration clock. Each rising edge of that clock loads one bit into a small shift register and advances a bit counter.

The states follow a fixed order: power-up, reset, configuration, a wait for the done line to rise, initialization and user mode. When the counter reaches the programmed bit length, the block lets go of done. Once the done line reads high, the block counts a set number of configuration-clock edges for initialization. It then removes the tri-state from user I/O and raises the user-mode flag. A configuration-error state branches off the configuration phase. The block enters it when the configuration clock stays quiet for too long. In that state it pulls status low again until the reconfigure request is pulsed.

The configuration clock, the data bit and both line read-backs are asynchronous to the system clock. Each passes through a synchronizer of the same depth, so data and clock stay aligned. The reconfigure request and the power-on-reset input are taken as synchronous to the system clock.

Top module: `cfg_target_seq`

## Requirements
- R1: While `por_done_i` is low, the block goes to power-up within one system clock. In power-up it pulls both status and done low, keeps user I/O tri-stated and holds `user_mode_o` at 0.
- R2: `user_io_hiz_o` is 1 in every state except user mode, and `user_mode_o` is 1 only in user mode.
- R3: With `por_done_i` high, a low `reconf_ni` forces the reset state from any state, including user mode and error. Reset pulls status and done low, sets tri-state and clears the bit counter and `cfg_word_o` to zero.
- R4: When `reconf_ni` is high in reset, the next state is configuration. Configuration lets go of status and keeps done pulled low.
- R5: A bit is accepted only on a synchronized rising edge of `cfg_clk_i`, only in configuration, and only while `status_line_i` reads high. Edges that arrive while the status line is held low externally are ignored.
- R6: Each accepted bit shifts into bit 0 of `cfg_word_o`, and earlier bits move one place toward the MSB.
- R7: Done stays pulled low until exactly `EXP_BITS` bits have been accepted. On the edge that accepts the last bit, the block lets go of done and stops taking bits.
- R8: After done is let go, the block waits for `done_line_i` to read high. It then counts `INIT_CLKS` rising edges of the configuration clock. After the last of these it clears `user_io_hiz_o` and sets `user_mode_o`. While the done line is held low, no initialization edge is counted.
- R9: In configuration, `TIMEOUT_CYC` system clocks with no configuration-clock rising edge put the block in the error state. Error pulls status low again and ignores further data until `reconf_ni` is pulsed low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_done_i | input | 1 | Power-on reset complete |
| reconf_ni | input | 1 | Active-low reconfigure request |
| cfg_clk_i | input | 1 | Configuration clock (asynchronous) |
| cfg_data_i | input | 1 | Serial configuration data |
| status_line_i | input | 1 | Read-back of the status line |
| done_line_i | input | 1 | Read-back of the done line |
| status_pull_low_o | output | 1 | 1: pull status line low |
| done_pull_low_o | output | 1 | 1: pull done line low |
| user_io_hiz_o | output | 1 | 1: user I/O tri-stated |
| user_mode_o | output | 1 | User mode reached |
| cfg_word_o | output | WORD_W | Most recently accepted data bits |

## Verification
The bench sweeps every bit count from one up to the programmed length. A design off by one in the length compare would let go of done one bit early or one bit late. It holds the status line low from outside while edges arrive; a design that counts before status reads high would finish early. It holds the done line low so that initialization cannot start, and it checks that user mode arrives after exactly the programmed number of init edges. It also covers a timeout, the sticky error state, an aborted load and a return from user mode. A design that does not clear the counter on reset would finish the next load early, and one without a sticky error would resume on new clock edges.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_RESET,
    ST_CONFIG,
    ST_ERROR,
    ST_DONE_WAIT,
    ST_INIT,
    ST_USER
  } seq_state_e;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int W        = 4,
  parameter int STAGES   = 2,
  parameter int EDGE_BIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic         rise_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[STAGES-1][EDGE_BIT];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1][EDGE_BIT] & ~prev_q;
endmodule

// File: rtl/cfg_intake.sv
module cfg_intake #(
  parameter int EXP_BITS    = 1024,
  parameter int WORD_W      = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic              watch_i,
  input  logic              rise_i,
  input  logic              data_i,
  output logic              last_bit_o,
  output logic              timeout_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(EXP_BITS + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] idle_q;
  logic             take;

  assign take       = accept_i & rise_i;
  assign last_bit_o = take && (cnt_q == CNT_W'(EXP_BITS - 1));
  assign timeout_o  = watch_i && !rise_i && (idle_q == TMR_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (take)    cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (WORD_W == 1) begin : g_word_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      word_o <= '0;
        else if (clear_i) word_o <= '0;
        else if (take)    word_o <= data_i;
      end
    end else begin : g_word_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      word_o <= '0;
        else if (clear_i) word_o <= '0;
        else if (take)    word_o <= {word_o[WORD_W-2:0], data_i};
      end
    end
  endgenerate

  // idle counter: system clocks since last config-clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_q <= '0;
    else if (!watch_i || rise_i) idle_q <= '0;
    else if (!timeout_o)         idle_q <= idle_q + 1'b1;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(EXP_BITS)); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0) && (word_o == '0)); // R3
  AST_IDLE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q < TMR_W'(TIMEOUT_CYC)); // R9
endmodule

// File: rtl/cfg_init_timer.sv
module cfg_init_timer #(
  parameter int INIT_CLKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rise_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(INIT_CLKS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && rise_i && (cnt_q == CNT_W'(INIT_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else if (rise_i)            cnt_q <= cnt_q + 1'b1;
  end

  AST_INIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(INIT_CLKS)); // R8
endmodule

// File: rtl/cfg_target_seq.sv
module cfg_target_seq
  import cfg_seq_pkg::*;
#(
  parameter int EXP_BITS    = 1024,
  parameter int WORD_W      = 8,
  parameter int INIT_CLKS   = 32,
  parameter int TIMEOUT_CYC = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_done_i,
  input  logic              reconf_ni,
  input  logic              cfg_clk_i,
  input  logic              cfg_data_i,
  input  logic              status_line_i,
  input  logic              done_line_i,
  output logic              status_pull_low_o,
  output logic              done_pull_low_o,
  output logic              user_io_hiz_o,
  output logic              user_mode_o,
  output logic [WORD_W-1:0] cfg_word_o
);
  localparam int PIN_W = 4;

  seq_state_e       state_q, state_d;
  logic [PIN_W-1:0] pins_s;
  logic             clk_rise, data_s, status_s, done_s;
  logic             last_bit, timeout, init_done;

  cfg_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .EDGE_BIT(0)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({done_line_i, status_line_i, cfg_data_i, cfg_clk_i}),
    .sync_o (pins_s),
    .rise_o (clk_rise)
  );

  assign data_s   = pins_s[1];
  assign status_s = pins_s[2];
  assign done_s   = pins_s[3];

  cfg_intake #(
    .EXP_BITS   (EXP_BITS),
    .WORD_W     (WORD_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_intake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_q == ST_RESET || state_q == ST_PWRUP),
    .accept_i  (state_q == ST_CONFIG && status_s),
    .watch_i   (state_q == ST_CONFIG),
    .rise_i    (clk_rise),
    .data_i    (data_s),
    .last_bit_o(last_bit),
    .timeout_o (timeout),
    .word_o    (cfg_word_o)
  );

  cfg_init_timer #(
    .INIT_CLKS(INIT_CLKS)
  ) u_init (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_INIT),
    .rise_i  (clk_rise),
    .expire_o(init_done)
  );

  always_comb begin
    state_d = state_q;
    if (!por_done_i) begin
      state_d = ST_PWRUP;
    end else if (state_q == ST_PWRUP) begin
      state_d = ST_RESET;
    end else if (!reconf_ni) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:     state_d = ST_CONFIG;
        ST_CONFIG: begin
          if (last_bit)     state_d = ST_DONE_WAIT;
          else if (timeout) state_d = ST_ERROR;
        end
        ST_DONE_WAIT: if (done_s) state_d = ST_INIT;
        ST_INIT:      if (init_done) state_d = ST_USER;
        default:      state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWRUP;
    else         state_q <= state_d;
  end

  assign status_pull_low_o = (state_q == ST_PWRUP) || (state_q == ST_RESET) ||
                             (state_q == ST_ERROR);
  assign done_pull_low_o   = (state_q == ST_PWRUP) || (state_q == ST_RESET) ||
                             (state_q == ST_CONFIG) || (state_q == ST_ERROR);
  assign user_mode_o       = (state_q == ST_USER);
  assign user_io_hiz_o     = (state_q != ST_USER);

  AST_POR_PULLS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_done_i |=> status_pull_low_o && done_pull_low_o && !user_mode_o); // R1
  AST_RESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_done_i && !reconf_ni) |=>
      status_pull_low_o && done_pull_low_o && user_io_hiz_o); // R3
  AST_STATUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_pull_low_o) |-> $past(state_q) == ST_RESET); // R4
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_pull_low_o) |-> $past(state_q) == ST_CONFIG); // R7
  AST_USER_FROM_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(user_io_hiz_o) |-> $past(state_q) == ST_INIT); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR && por_done_i && reconf_ni) |=>
      state_q == ST_ERROR && status_pull_low_o); // R9
endmodule

// File: tb/cfg_target_seq_bench.sv
module cfg_target_seq_bench;
  localparam int EXP  = 6;
  localparam int WW   = 8;
  localparam int INIT = 3;
  localparam int TMO  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic por_done = 1'b0, reconf_n = 1'b1, cfg_clk = 1'b0, cfg_data = 1'b0;
  logic status_hold = 1'b0, done_hold = 1'b0;
  logic status_lo, done_lo, hiz, umode;
  logic [WW-1:0] word;
  logic [WW-1:0] exp_word;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wire status_line = ~status_lo & ~status_hold;
  wire done_line   = ~done_lo & ~done_hold;

  cfg_target_seq #(
    .EXP_BITS(EXP), .WORD_W(WW), .INIT_CLKS(INIT), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
  ) u_cfg_target_seq (
    .clk_i(clk), .rst_ni(rst_n), .por_done_i(por_done), .reconf_ni(reconf_n),
    .cfg_clk_i(cfg_clk), .cfg_data_i(cfg_data), .status_line_i(status_line),
    .done_line_i(done_line), .status_pull_low_o(status_lo), .done_pull_low_o(done_lo),
    .user_io_hiz_o(hiz), .user_mode_o(umode), .cfg_word_o(word)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    cfg_data = b;
    wait_cyc(2);
    cfg_clk = 1'b1;
    wait_cyc(4);
    cfg_clk = 1'b0;
    wait_cyc(4);
  endtask

  // send n bits; track the expected word while bits are still accepted
  task automatic send(input int n, input int seed, input bit track);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = logic'(((seed * 7 + i * 3) >> 1) & 1);
      if (track) exp_word = {exp_word[WW-2:0], b};
      pulse(b);
    end
  endtask

  task automatic reconf_pulse();
    reconf_n = 1'b0;
    wait_cyc(3);
    reconf_n = 1'b1;
    wait_cyc(6);
    exp_word = '0;
  endtask

  initial begin
    exp_word = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1: power-up pulls both low, I/O tri-stated
    chk("R1 status", int'(status_lo), 1);
    chk("R1 done", int'(done_lo), 1);
    chk("R2 hiz", int'(hiz), 1);
    chk("R1 umode", int'(umode), 0);

    por_done = 1'b1;
    reconf_n = 1'b0;
    wait_cyc(4);
    chk("R3 status", int'(status_lo), 1);
    chk("R3 done", int'(done_lo), 1);
    reconf_n = 1'b1;
    wait_cyc(2);
    chk("R4 status released", int'(status_lo), 0);
    chk("R4 done held", int'(done_lo), 1);

    // R7/R6 sweep over every bit count
    for (int k = 1; k <= EXP; k++) begin
      reconf_pulse();
      send(k, k, 1'b1);
      chk("R7 done vs count", int'(done_lo), (k < EXP) ? 1 : 0);
      chk("R6 word", int'(word), int'(exp_word));
      chk("R9 no early error", int'(status_lo), 0);
    end

    // R5: edges while status held low are ignored
    status_hold = 1'b1;
    reconf_pulse();
    send(3, 11, 1'b0);
    chk("R5 word untouched", int'(word), 0);
    status_hold = 1'b0;
    wait_cyc(4);
    send(EXP - 1, 5, 1'b1);
    chk("R5 done held", int'(done_lo), 1);
    send(1, 9, 1'b1);
    chk("R5 done released", int'(done_lo), 0);
    chk("R6 word after hold", int'(word), int'(exp_word));

    // R8: done line held low blocks init
    done_hold = 1'b1;
    reconf_pulse();
    send(EXP, 3, 1'b1);
    chk("R7 done released", int'(done_lo), 0);
    send(INIT + 2, 1, 1'b0);
    chk("R8 no user while held", int'(umode), 0);
    chk("R8 hiz while held", int'(hiz), 1);
    chk("R6 word frozen after last bit", int'(word), int'(exp_word));
    done_hold = 1'b0;
    wait_cyc(6);
    send(INIT - 1, 2, 1'b0);
    chk("R8 user before last init edge", int'(umode), 0);
    send(1, 2, 1'b0);
    chk("R8 user mode", int'(umode), 1);
    chk("R2 hiz off in user", int'(hiz), 0);

    // R3 from user mode
    reconf_n = 1'b0;
    wait_cyc(2);
    chk("R3 status from user", int'(status_lo), 1);
    chk("R3 done from user", int'(done_lo), 1);
    chk("R3 hiz from user", int'(hiz), 1);
    chk("R3 umode from user", int'(umode), 0);
    reconf_n = 1'b1;
    wait_cyc(6);
    exp_word = '0;

    // R9 timeout
    send(2, 4, 1'b1);
    wait_cyc(TMO - 12);
    chk("R9 not yet", int'(status_lo), 0);
    wait_cyc(20);
    chk("R9 error pulls status", int'(status_lo), 1);
    send(EXP, 6, 1'b0);
    chk("R9 sticky status", int'(status_lo), 1);
    chk("R9 done held", int'(done_lo), 1);
    reconf_pulse();
    chk("R9 cleared by reconf", int'(status_lo), 0);
    send(EXP, 8, 1'b1);
    chk("R3 fresh count after error", int'(done_lo), 0);

    // R3 abort mid-load clears count
    reconf_pulse();
    send(4, 2, 1'b0);
    reconf_pulse();
    chk("R3 word cleared", int'(word), 0);
    send(EXP - 1, 3, 1'b1);
    chk("R3 count cleared", int'(done_lo), 1);
    send(1, 3, 1'b1);
    chk("R3 load completes", int'(done_lo), 0);

    // R1 power-on reset from a late state
    por_done = 1'b0;
    wait_cyc(2);
    chk("R1 por status", int'(status_lo), 1);
    chk("R1 por done", int'(done_lo), 1);
    chk("R2 por hiz", int'(hiz), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule